// File: doc/BRIEF.md
# Run-Time Configurable Two-Level Logic Array

This block evaluates a set of sum-of-products equations whose structure is held in registers rather than fixed in gates. Every primary input enters the first plane as two literals, its true and complemented form. Each product term is the AND of whichever literals its row selects. Each output is the OR of whichever product terms its row selects. Several outputs may draw on the same product term, so equations that share terms need fewer rows than they have terms in total.

The connection pattern is loaded one row at a time through a synchronous write port. Row addresses 0 to N_TERM-1 hold the literal-select rows of the product terms. Addresses N_TERM to N_TERM+N_OUT-1 hold the term-select rows of the outputs. The evaluation path from `in_vec` to `out_vec` contains no storage. A combinational readback port returns any stored row.

Two encodings fall out of the plane rules and give constant outputs. A term row with no bits set yields a term that is always 1. A term row that selects both literals of one input yields a term that is always 0. An output row with no bits set yields an output that is always 0.

Top module: `pla_array`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every stored row is cleared. After reset, every readback returns 0 and every output is 0 for any input.
- R2: When `cfg_we` is high at a rising edge and `cfg_addr` is below N_TERM+N_OUT, the row at `cfg_addr` takes `cfg_wdata`. Term rows keep bits [2*N_IN-1:0] and output rows keep bits [N_TERM-1:0]. `rd_data` shows the row at `rd_addr` zero-extended to the port width, with no clock delay.
- R3: In a term row, bit 2*i selects the true literal of `in_vec[i]` and bit 2*i+1 selects its complement. Product term j is 1 exactly when every selected literal of row j is 1.
- R4: A product term whose row has no bits set is constant 1.
- R5: A product term whose row sets both bit 2*i and bit 2*i+1 for some i is constant 0.
- R6: In the row of output k (address N_TERM+k), bit j selects product term j. `out_vec[k]` is the OR of the selected terms.
- R7: An output whose row has no bits set is constant 0.
- R8: One product term may feed several outputs at once, and each of those outputs follows it.
- R9: A write to an address of N_TERM+N_OUT or above changes no stored row and no output. A readback of such an address returns 0.
- R10: A change on `in_vec` reaches `out_vec` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset, clears all rows |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | AW = clog2(N_TERM+N_OUT) | Row address for writes |
| cfg_wdata | input | DW = max(2*N_IN, N_TERM) | Row contents for writes |
| rd_addr | input | AW | Row address for readback |
| rd_data | output | DW | Stored row at `rd_addr`, zero-extended |
| in_vec | input | N_IN | Primary inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The bench builds the array with its default sizing of four inputs, three outputs and six product terms. At that size all sixteen input combinations can be applied after every reprogramming, so each loaded pattern is checked against the whole truth table rather than a sample. The 4-bit address field has seven codes above the last row, which makes the ignored-write and zero-readback rule reachable. Output rows are narrower than the data port, so the truncation of an over-wide write can be seen on readback.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    ROW_TERM = 2'd0,
    ROW_OUT  = 2'd1,
    ROW_NONE = 2'd2
  } row_kind_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int addr_width(input int rows);
    return (rows > 1) ? $clog2(rows) : 1;
  endfunction

  // Term rows come first, output rows follow, everything above is unmapped.
  function automatic row_kind_e classify_row(input int addr, input int n_term, input int n_rows);
    if (addr < n_term) return ROW_TERM;
    if (addr < n_rows) return ROW_OUT;
    return ROW_NONE;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [DW-1:0]             cfg_wdata,
  input  logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic [N_TERM*2*N_IN-1:0]  and_flat,
  output logic [N_OUT*N_TERM-1:0]   or_flat
);
  localparam int LW = 2 * N_IN;
  localparam int ROWS = N_TERM + N_OUT;
  localparam logic [AW-1:0] OUT_BASE = AW'(N_TERM);

  logic [LW-1:0]     term_q [N_TERM];
  logic [N_TERM-1:0] out_q  [N_OUT];

  row_kind_e wr_kind;
  row_kind_e rd_kind;
  logic [AW-1:0] wr_out_idx;
  logic [AW-1:0] rd_out_idx;

  assign wr_kind    = classify_row(int'(cfg_addr), N_TERM, ROWS);
  assign rd_kind    = classify_row(int'(rd_addr), N_TERM, ROWS);
  assign wr_out_idx = cfg_addr - OUT_BASE;
  assign rd_out_idx = rd_addr - OUT_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N_TERM; j++) term_q[j] <= '0;
      for (int k = 0; k < N_OUT; k++)  out_q[k]  <= '0;
    end else if (cfg_we) begin
      case (wr_kind)
        ROW_TERM: term_q[cfg_addr]  <= cfg_wdata[LW-1:0];
        ROW_OUT:  out_q[wr_out_idx] <= cfg_wdata[N_TERM-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rd_kind)
      ROW_TERM: rd_data = DW'(term_q[rd_addr]);
      ROW_OUT:  rd_data = DW'(out_q[rd_out_idx]);
      default:  rd_data = '0;
    endcase
  end

  for (genvar j = 0; j < N_TERM; j++) begin : g_term_flat
    assign and_flat[j*LW +: LW] = term_q[j];
  end
  for (genvar k = 0; k < N_OUT; k++) begin : g_out_flat
    assign or_flat[k*N_TERM +: N_TERM] = out_q[k];
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6
) (
  input  logic [N_IN-1:0]           in_vec,
  input  logic [N_TERM*2*N_IN-1:0]  and_flat,
  output logic [N_TERM-1:0]         term_vec
);
  localparam int LW = 2 * N_IN;

  // Literal 2*i is the input itself, literal 2*i+1 its complement.
  function automatic logic [LW-1:0] make_literals(input logic [N_IN-1:0] v);
    logic [LW-1:0] l;
    for (int i = 0; i < N_IN; i++) begin
      l[2*i]   = v[i];
      l[2*i+1] = ~v[i];
    end
    return l;
  endfunction

  logic [LW-1:0] lit_vec;
  assign lit_vec = make_literals(in_vec);

  // An unselected literal contributes a 1, so an empty row gives a 1.
  for (genvar j = 0; j < N_TERM; j++) begin : g_term
    logic [LW-1:0] sel;
    assign sel         = and_flat[j*LW +: LW];
    assign term_vec[j] = &(~sel | lit_vec);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6
) (
  input  logic [N_TERM-1:0]        term_vec,
  input  logic [N_OUT*N_TERM-1:0]  or_flat,
  output logic [N_OUT-1:0]         out_vec
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign out_vec[k] = |(or_flat[k*N_TERM +: N_TERM] & term_vec);
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6,
  localparam int ROWS  = N_TERM + N_OUT,
  localparam int AW    = addr_width(ROWS),
  localparam int DW    = max_int(2 * N_IN, N_TERM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  logic [N_TERM*2*N_IN-1:0] and_flat;
  logic [N_OUT*N_TERM-1:0]  or_flat;
  logic [N_TERM-1:0]        term_vec;

  pla_cfg_store #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .AW(AW), .DW(DW)
  ) store_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .and_flat(and_flat), .or_flat(or_flat)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) and_i (
    .in_vec(in_vec), .and_flat(and_flat), .term_vec(term_vec)
  );

  pla_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) or_i (
    .term_vec(term_vec), .or_flat(or_flat), .out_vec(out_vec)
  );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cfg_we,
  input logic [AW-1:0]             cfg_addr,
  input logic [DW-1:0]             cfg_wdata,
  input logic [N_TERM*2*N_IN-1:0]  and_flat,
  input logic [N_OUT*N_TERM-1:0]   or_flat,
  input logic [N_TERM-1:0]         term_vec,
  input logic [N_OUT-1:0]          out_vec
);
  localparam int LW = 2 * N_IN;
  localparam int ROWS = N_TERM + N_OUT;

  function automatic logic [DW-1:0] stored_row(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    for (int j = 0; j < N_TERM; j++)
      if (int'(a) == j) r = DW'(and_flat[j*LW +: LW]);
    for (int k = 0; k < N_OUT; k++)
      if (int'(a) == N_TERM + k) r = DW'(or_flat[k*N_TERM +: N_TERM]);
    return r;
  endfunction

  // Last accepted write, held one cycle to compare with the stored row.
  logic          seen_wr;
  logic [AW-1:0] seen_addr;
  logic [DW-1:0] seen_data;
  logic [DW-1:0] seen_expect;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_wr   <= 1'b0;
      seen_addr <= '0;
      seen_data <= '0;
    end else begin
      seen_wr   <= cfg_we && (int'(cfg_addr) < ROWS);
      seen_addr <= cfg_addr;
      seen_data <= cfg_wdata;
    end
  end

  assign seen_expect = (int'(seen_addr) < N_TERM) ? DW'(seen_data[LW-1:0])
                                                  : DW'(seen_data[N_TERM-1:0]);

  logic [N_TERM-1:0] term_empty;
  logic [N_TERM-1:0] term_contra;
  logic [N_OUT-1:0]  out_empty;

  always_comb begin
    for (int j = 0; j < N_TERM; j++) begin
      term_empty[j]  = (and_flat[j*LW +: LW] == '0);
      term_contra[j] = 1'b0;
      for (int i = 0; i < N_IN; i++)
        if (and_flat[j*LW + 2*i] && and_flat[j*LW + 2*i + 1]) term_contra[j] = 1'b1;
    end
    for (int k = 0; k < N_OUT; k++)
      out_empty[k] = (or_flat[k*N_TERM +: N_TERM] == '0);
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (and_flat == '0) && (or_flat == '0) && (out_vec == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    seen_wr |-> stored_row(seen_addr) == seen_expect);

  assert_empty_term_one_R4: assert property (@(posedge clk) disable iff (rst)
    (term_vec & term_empty) == term_empty);

  assert_contra_term_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (term_vec & term_contra) == '0);

  assert_empty_out_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (out_vec & out_empty) == '0);

  assert_unmapped_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_addr) >= ROWS) |=> $stable(and_flat) && $stable(or_flat));

endmodule

bind pla_array pla_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .AW(AW), .DW(DW)
) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .and_flat(and_flat), .or_flat(or_flat), .term_vec(term_vec), .out_vec(out_vec)
);

// File: tb/pla_array_tb_top.sv
module pla_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN   = 4;
  localparam int N_OUT  = 3;
  localparam int N_TERM = 6;
  localparam int ROWS   = N_TERM + N_OUT;
  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int LW     = 2 * N_IN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [N_IN-1:0] in_vec = '0;
  logic [N_OUT-1:0] out_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_vec(in_vec), .out_vec(out_vec)
  );

  typedef struct {
    logic [DW-1:0] exp;
    bit            is_rb;
    string         tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event chk_ev;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference rows kept by the bench.
  logic [DW-1:0] m_rows [ROWS];

  function automatic logic [N_OUT-1:0] model_eval(input logic [N_IN-1:0] v);
    logic [N_TERM-1:0] t;
    logic [N_OUT-1:0] o;
    for (int j = 0; j < N_TERM; j++) begin
      t[j] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (m_rows[j][2*i] && !v[i]) t[j] = 1'b0;
        if (m_rows[j][2*i+1] && v[i]) t[j] = 1'b0;
      end
    end
    for (int k = 0; k < N_OUT; k++) begin
      o[k] = 1'b0;
      for (int j = 0; j < N_TERM; j++)
        if (m_rows[N_TERM+k][j] && t[j]) o[k] = 1'b1;
    end
    return o;
  endfunction

  function automatic logic [DW-1:0] model_row(input int a);
    return (a < ROWS) ? m_rows[a] : '0;
  endfunction

  task automatic clear_model();
    for (int a = 0; a < ROWS; a++) m_rows[a] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
  endtask

  task automatic write_row(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = AW'(a);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < N_TERM) m_rows[a] = d & DW'({LW{1'b1}});
    else if (a < ROWS) m_rows[a] = d & DW'({N_TERM{1'b1}});
  endtask

  task automatic expect_out(input logic [N_IN-1:0] v, input string tag);
    sb_item_t it;
    in_vec = v;
    it.exp = DW'(model_eval(v));
    it.is_rb = 1'b0;
    it.tag = tag;
    sb_q.push_back(it);
    #1 -> chk_ev;
    #1;
  endtask

  task automatic expect_rb(input int a, input string tag);
    sb_item_t it;
    rd_addr = AW'(a);
    it.exp = model_row(a);
    it.is_rb = 1'b1;
    it.tag = tag;
    sb_q.push_back(it);
    #1 -> chk_ev;
    #1;
  endtask

  task automatic sweep_inputs(input string tag);
    for (int v = 0; v < (1 << N_IN); v++) expect_out(N_IN'(v), tag);
  endtask

  task automatic print_summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops expected items and compares with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [DW-1:0] act;
        it = sb_q.pop_front();
        act = it.is_rb ? rd_data : DW'(out_vec);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=completion");
      print_summary();
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();

    // R1: everything clear after reset
    for (int a = 0; a < ROWS; a++) expect_rb(a, "R1 readback after reset");
    sweep_inputs("R1 outputs after reset");

    // Terms: T0=x0x1, T1=~x0~x1~x2~x3, T2=x0~x2, T3=~x0x2x3, T4=x1, T5=~x0~x1~x3
    write_row(0, 8'h05);
    write_row(1, 8'hAA);
    write_row(2, 8'h21);
    write_row(3, 8'h52);
    write_row(4, 8'h04);
    write_row(5, 8'h8A);
    write_row(6, 8'h03);
    write_row(7, 8'h1C);
    write_row(8, 8'h25);
    for (int a = 0; a < ROWS; a++) expect_rb(a, "R2 readback of written row");
    sweep_inputs("R3 R6 sum of products");
    expect_out(4'b0011, "R8 shared term drives out0 and out2");

    // R10: input change with no clock edge between
    @(posedge clk);
    #1;
    expect_out(4'b0100, "R10 combinational path");
    expect_out(4'b0010, "R10 combinational path");

    // R2: over-wide data to an output row is truncated
    write_row(7, 8'hFF);
    expect_rb(7, "R2 output row truncation");

    // Constant encodings
    write_row(0, 8'h00);
    write_row(6, 8'h01);
    write_row(1, 8'h03);
    write_row(8, 8'h02);
    write_row(7, 8'h00);
    sweep_inputs("R4 R5 R7 constant outputs");
    expect_out(4'b1010, "R4 empty term gives constant one");
    expect_out(4'b0000, "R5 contradictory term gives zero");
    expect_out(4'b1111, "R7 empty output row gives zero");

    // R9: writes above the last row are dropped
    for (int a = ROWS; a < (1 << AW); a++) write_row(a, 8'hFF);
    for (int a = 0; a < (1 << AW); a++) expect_rb(a, "R9 unmapped write ignored");
    sweep_inputs("R9 outputs unchanged");

    // R1: reset in the middle of a run
    do_reset();
    for (int a = 0; a < ROWS; a++) expect_rb(a, "R1 readback after second reset");
    sweep_inputs("R1 outputs after second reset");

    #(CLK_PERIOD);
    done = 1'b1;
    print_summary();
    $finish;
  end

endmodule